// File: doc/BRIEF.md
# SDRAM Bank State Protocol Checker

This block watches the command pins of a four-bank SDRAM and, at every rising clock edge, turns chip select, row strobe, column strobe, write enable and clock enable into one decoded command. It keeps a model of each bank (idle, open with a row number, or open with a self-timed close pending) and raises a sticky error with a 3-bit cause when the command stream breaks a bank rule. It sits beside a memory controller or in a verification environment; it never drives the memory.

Each bank runs a small state machine with states `BK_IDLE`, `BK_OPEN` and `BK_AUTOPRE`. Transitions: *activate* (`BK_IDLE`→`BK_OPEN`), *close* (`BK_OPEN` or `BK_AUTOPRE`→`BK_IDLE` on a precharge), *arm* (`BK_OPEN`→`BK_AUTOPRE` on a read or write with auto precharge), *expire* (`BK_AUTOPRE`→`BK_IDLE` when the burst counter runs out). A mode timer runs states `MR_READY` and `MR_WAIT`: *load* (`MR_READY`→`MR_WAIT`, or reload in `MR_WAIT`, on a legal mode load) and *settle* (`MR_WAIT`→`MR_READY` once the wait window is over). Commands that break a bank rule have no effect on bank or mode state; a command issued inside the mode-load window is flagged but still executed.

Top module: `sdram_bank_guard`

## Requirements
- R1: `cmd_code` shows, one cycle after each edge, the command sampled there: 0 inhibit (cs_n high, other pins ignored), 1 NOP (ras,cas,we = 1,1,1), 2 activate (0,1,1), 3 read (1,0,1), 4 write (1,0,0), 5 burst stop (1,1,0), 6 precharge (0,1,0), 7 auto refresh (0,0,1 with cke high), 8 self refresh (0,0,1 with cke low), 9 mode load (0,0,0).
- R2: An activate to an idle bank `ba` sets `bank_open[ba]` and shows `addr` in `bank_row[ba*12 +: 12]` after that edge; an idle bank's row field reads 0.
- R3: An activate to an open bank gives cause 1 and leaves that bank's row unchanged.
- R4: A precharge with addr[10] low closes only bank `ba`; with addr[10] high it closes every bank whatever `ba` holds.
- R5: A read or write to an idle bank gives cause 2 and changes no bank.
- R6: A read or write with addr[10] high to an open bank closes it after exactly BL edges, BL taken from addr[2:0] of the last legal mode load: 0→1, 1→2, 2→4, 3→8, codes 4..6→1; BL is 1 after reset.
- R7: With mode code 7 (full page), addr[10] on a read or write is ignored and the bank stays open.
- R8: A read or write to a bank with a pending self-timed close gives cause 6 and is ignored; an explicit precharge closes that bank at once.
- R9: A mode load while any bank is open gives cause 3 and leaves the burst setting unchanged; auto or self refresh while any bank is open gives cause 4.
- R10: After a legal mode load at edge n, any command other than inhibit or NOP at edges n+1 .. n+TMRD-1 gives cause 5 (bank-rule causes take precedence) and is still executed.
- R11: `err_flag` is sticky and `err_cause` keeps the first violation; `clr_err` high at an edge clears both and discards any violation at that edge.
- R12: Reset (rst_n low) leaves all banks idle, rows 0, `cmd_code` 0, `err_flag` 0 and `err_cause` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_err | input | 1 | Synchronous clear of the error latch |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable (separates auto from self refresh) |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address bus (row, column, mode code, bit 10 all/auto flag) |
| cmd_code | output | 4 | Registered decoded command |
| bank_open | output | 4 | One bit per bank, high when a row is open |
| bank_row | output | 48 | Open row of each bank, 12 bits per bank, 0 when idle |
| err_flag | output | 1 | Sticky violation flag |
| err_cause | output | 3 | Cause of the first violation |

## Verification
The bench targets the self-timed close: a design off by one in the burst counter closes the bank an edge early or late, and one that loads the burst setting from a rejected mode load shows the wrong length. It issues a command in the edge right after a mode load and again once the window has passed, so a timer of the wrong length or one that misses inhibit as a non-command is exposed. An all-bank precharge with a nonzero bank select catches a design that decodes bank select anyway, and repeated violations before a clear catch a cause register that gets overwritten. A clear that coincides with a violation shows whether the clear really wins.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT = 4'd0,
        CMD_NOP     = 4'd1,
        CMD_ACTIVE  = 4'd2,
        CMD_READ    = 4'd3,
        CMD_WRITE   = 4'd4,
        CMD_BSTOP   = 4'd5,
        CMD_PRECH   = 4'd6,
        CMD_AREF    = 4'd7,
        CMD_SREF    = 4'd8,
        CMD_MLOAD   = 4'd9
    } sd_cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_AUTOPRE = 2'd2
    } bank_state_e;

    typedef enum logic {
        MR_READY = 1'b0,
        MR_WAIT  = 1'b1
    } mode_state_e;

    localparam int          BURST_W        = 3;
    localparam int          FLAG_BIT       = 10;
    localparam logic [2:0]  MODE_FULL_PAGE = 3'd7;

    localparam logic [2:0] CAUSE_NONE     = 3'd0;
    localparam logic [2:0] CAUSE_ACT_OPEN = 3'd1;
    localparam logic [2:0] CAUSE_ACC_IDLE = 3'd2;
    localparam logic [2:0] CAUSE_MLOAD    = 3'd3;
    localparam logic [2:0] CAUSE_REFRESH  = 3'd4;
    localparam logic [2:0] CAUSE_WINDOW   = 3'd5;
    localparam logic [2:0] CAUSE_ACC_PEND = 3'd6;

    // Burst length minus one for a mode code; reserved codes act as length 1.
    function automatic logic [BURST_W-1:0] burst_last(input logic [2:0] code);
        logic [BURST_W-1:0] r;
        unique case (code)
            3'd1:    r = 3'd1;
            3'd2:    r = 3'd3;
            3'd3:    r = 3'd7;
            default: r = 3'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_guard_pkg::*;
(
    input  logic    cs_n,
    input  logic    ras_n,
    input  logic    cas_n,
    input  logic    we_n,
    input  logic    cke,
    output sd_cmd_e cmd
);

    always_comb begin
        cmd = CMD_INHIBIT;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACTIVE;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b110:  cmd = CMD_BSTOP;
                3'b010:  cmd = CMD_PRECH;
                3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
                3'b000:  cmd = CMD_MLOAD;
                default: cmd = CMD_INHIBIT;
            endcase
        end
    end

endmodule

// File: rtl/sdram_mode_timer.sv
module sdram_mode_timer
    import sdram_guard_pkg::*;
#(
    parameter int TMRD = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [2:0]         code_in,
    output logic [BURST_W-1:0] blen_last,
    output logic               full_page,
    output logic               busy
);

    localparam int CNT_W = (TMRD > 1) ? $clog2(TMRD + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = (TMRD > 1) ? CNT_W'(TMRD - 1) : '0;

    mode_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [2:0]       code_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MR_READY;
            cnt_q   <= '0;
            code_q  <= 3'd0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load_en) code_q <= code_in;
        end
    end

    // transitions: load, settle
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            MR_READY: begin
                if (load_en && (TMRD > 1)) begin
                    state_d = MR_WAIT;
                    cnt_d   = CNT_LOAD;
                end
            end
            MR_WAIT: begin
                if (load_en) begin
                    cnt_d = CNT_LOAD;
                end else if (cnt_q <= CNT_W'(1)) begin
                    state_d = MR_READY;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: state_d = MR_READY;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q == MR_WAIT);
        blen_last = burst_last(code_q);
        full_page = (code_q == MODE_FULL_PAGE);
    end

    a_r10_load_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && (TMRD > 1)) |=> busy);

    a_r6_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(blen_last));

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_guard_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act_en,
    input  logic               rw_en,
    input  logic               ap_req,
    input  logic               pre_en,
    input  logic [ROW_W-1:0]   row_in,
    input  logic [BURST_W-1:0] blen_last,
    output logic               open_o,
    output logic               pending_o,
    output logic [ROW_W-1:0]   row_o
);

    bank_state_e        state_q, state_d;
    logic [BURST_W-1:0] cnt_q, cnt_d;
    logic [ROW_W-1:0]   row_q, row_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            row_q   <= row_d;
        end
    end

    // transitions: activate, close, arm, expire
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        row_d   = row_q;
        unique case (state_q)
            BK_IDLE: begin
                if (act_en) begin
                    state_d = BK_OPEN;
                    row_d   = row_in;
                end
            end
            BK_OPEN: begin
                if (pre_en) begin
                    state_d = BK_IDLE;
                end else if (rw_en && ap_req) begin
                    state_d = BK_AUTOPRE;
                    cnt_d   = blen_last;
                end
            end
            BK_AUTOPRE: begin
                if (pre_en || (cnt_q == '0)) begin
                    state_d = BK_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - BURST_W'(1);
                end
            end
            default: state_d = BK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        open_o    = (state_q != BK_IDLE);
        pending_o = (state_q == BK_AUTOPRE);
        row_o     = open_o ? row_q : '0;
    end

    a_r2_activate_opens: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |=> (open_o && row_o == $past(row_in)));

    a_r4_precharge_closes: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |=> !open_o);

    a_r8_pending_is_open: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o |-> open_o);

    a_r6_armed_bank_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_en && ap_req && !pre_en && open_o) |=> open_o);

endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
    import sdram_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int TMRD      = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_err,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic                       cke,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [ROW_W-1:0]           addr,
    output logic [3:0]                 cmd_code,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row,
    output logic                       err_flag,
    output logic [2:0]                 err_cause
);

    localparam int BA_W = $clog2(NUM_BANKS);

    sd_cmd_e               cmd_now;
    logic [NUM_BANKS-1:0]  pend;
    logic [NUM_BANKS-1:0]  act_en, rw_en, pre_en;
    logic [BURST_W-1:0]    blen_last;
    logic                  full_page, mr_busy, load_en;
    logic                  any_open, sel_open, sel_pend, exec_cmd, ap_req;
    logic [2:0]            bank_cause, viol;
    logic [3:0]            cmd_q;
    logic                  err_q;
    logic [2:0]            cause_q;

    sdram_cmd_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cke   (cke),
        .cmd   (cmd_now)
    );

    sdram_mode_timer #(.TMRD(TMRD)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .code_in   (addr[2:0]),
        .blen_last (blen_last),
        .full_page (full_page),
        .busy      (mr_busy)
    );

    // legality of the sampled command against current bank state
    always_comb begin
        any_open = |bank_open;
        sel_open = bank_open[ba];
        sel_pend = pend[ba];
        exec_cmd = (cmd_now != CMD_INHIBIT) && (cmd_now != CMD_NOP);
        ap_req   = addr[FLAG_BIT] && !full_page;

        bank_cause = CAUSE_NONE;
        unique case (cmd_now)
            CMD_ACTIVE: if (sel_open) bank_cause = CAUSE_ACT_OPEN;
            CMD_READ, CMD_WRITE: begin
                if (!sel_open)     bank_cause = CAUSE_ACC_IDLE;
                else if (sel_pend) bank_cause = CAUSE_ACC_PEND;
            end
            CMD_MLOAD:          if (any_open) bank_cause = CAUSE_MLOAD;
            CMD_AREF, CMD_SREF: if (any_open) bank_cause = CAUSE_REFRESH;
            default:            bank_cause = CAUSE_NONE;
        endcase

        if (bank_cause != CAUSE_NONE)  viol = bank_cause;
        else if (mr_busy && exec_cmd)  viol = CAUSE_WINDOW;
        else                           viol = CAUSE_NONE;

        load_en = (cmd_now == CMD_MLOAD) && !any_open;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit       = (ba == BA_W'(b));
        assign act_en[b] = (cmd_now == CMD_ACTIVE) && hit && (bank_cause == CAUSE_NONE);
        assign rw_en[b]  = ((cmd_now == CMD_READ) || (cmd_now == CMD_WRITE)) && hit
                           && (bank_cause == CAUSE_NONE);
        assign pre_en[b] = (cmd_now == CMD_PRECH) && (addr[FLAG_BIT] || hit);

        sdram_bank_fsm #(.ROW_W(ROW_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_en    (act_en[b]),
            .rw_en     (rw_en[b]),
            .ap_req    (ap_req),
            .pre_en    (pre_en[b]),
            .row_in    (addr),
            .blen_last (blen_last),
            .open_o    (bank_open[b]),
            .pending_o (pend[b]),
            .row_o     (bank_row[b*ROW_W +: ROW_W])
        );
    end

    // command and error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= 4'd0;
            err_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            cmd_q <= cmd_now;
            if (clr_err) begin
                err_q   <= 1'b0;
                cause_q <= CAUSE_NONE;
            end else if (!err_q && (viol != CAUSE_NONE)) begin
                err_q   <= 1'b1;
                cause_q <= viol;
            end
        end
    end

    always_comb begin
        cmd_code  = cmd_q;
        err_flag  = err_q;
        err_cause = cause_q;
    end

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_err) |=> err_flag);

    a_r11_first_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_err) |=> $stable(err_cause));

    a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> (!err_flag && err_cause == 3'd0));

    a_r3_act_on_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == CMD_ACTIVE && bank_open[ba] && !clr_err) |=> err_flag);

    a_r9_load_with_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == CMD_MLOAD && any_open && !clr_err && !err_flag)
        |=> (err_flag && err_cause == 3'd3));

    a_r10_window_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_busy && exec_cmd && !clr_err) |=> err_flag);

    a_r4_all_close: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == CMD_PRECH && addr[FLAG_BIT]) |=> (bank_open == '0));

endmodule

// File: tb/sdram_bank_guard_bench.sv
module sdram_bank_guard_bench;

    localparam logic [3:0] C_INH = 4'd0, C_NOP = 4'd1, C_ACT = 4'd2, C_RD = 4'd3,
                           C_WR = 4'd4, C_BST = 4'd5, C_PRE = 4'd6, C_AREF = 4'd7,
                           C_SREF = 4'd8, C_MLD = 4'd9;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [11:0] addr;
        logic [3:0]  open;
        logic        err;
        logic [2:0]  cause;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{C_NOP,  2'd0, 12'h000, 4'b0000, 1'b0, 3'd0},
        '{C_MLD,  2'd0, 12'h003, 4'b0000, 1'b0, 3'd0},
        '{C_NOP,  2'd0, 12'h000, 4'b0000, 1'b0, 3'd0},
        '{C_ACT,  2'd1, 12'h123, 4'b0010, 1'b0, 3'd0},
        '{C_ACT,  2'd2, 12'hABC, 4'b0110, 1'b0, 3'd0},
        '{C_RD,   2'd1, 12'h000, 4'b0110, 1'b0, 3'd0},
        '{C_WR,   2'd2, 12'h004, 4'b0110, 1'b0, 3'd0},
        '{C_PRE,  2'd1, 12'h000, 4'b0100, 1'b0, 3'd0},
        '{C_ACT,  2'd0, 12'h7FF, 4'b0101, 1'b0, 3'd0},
        '{C_PRE,  2'd3, 12'h400, 4'b0000, 1'b0, 3'd0},
        '{C_AREF, 2'd0, 12'h000, 4'b0000, 1'b0, 3'd0},
        '{C_BST,  2'd0, 12'h000, 4'b0000, 1'b0, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_err = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic [3:0]  cmd_code;
    logic [3:0]  bank_open;
    logic [47:0] bank_row;
    logic        err_flag;
    logic [2:0]  err_cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sdram_bank_guard u_sdram_bank_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_err   (clr_err),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .cke       (cke),
        .ba        (ba),
        .addr      (addr),
        .cmd_code  (cmd_code),
        .bank_open (bank_open),
        .bank_row  (bank_row),
        .err_flag  (err_flag),
        .err_cause (err_cause)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [1:0] b,
                         input logic [11:0] a, input logic clr);
        @(negedge clk);
        cs_n = (c == C_INH);
        cke  = (c != C_SREF);
        case (c)
            C_ACT:        {ras_n, cas_n, we_n} = 3'b011;
            C_RD:         {ras_n, cas_n, we_n} = 3'b101;
            C_WR:         {ras_n, cas_n, we_n} = 3'b100;
            C_BST:        {ras_n, cas_n, we_n} = 3'b110;
            C_PRE:        {ras_n, cas_n, we_n} = 3'b010;
            C_AREF,C_SREF:{ras_n, cas_n, we_n} = 3'b001;
            C_MLD:        {ras_n, cas_n, we_n} = 3'b000;
            default:      {ras_n, cas_n, we_n} = 3'b111;
        endcase
        ba = b; addr = a; clr_err = clr;
        @(posedge clk);
        #2;
    endtask

    task automatic err_is(input string req, input logic e, input logic [2:0] c);
        chk(req, {47'd0, err_flag}, {47'd0, e});
        chk(req, {45'd0, err_cause}, {45'd0, c});
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R12 reset state
        chk("R12 open", {44'd0, bank_open}, 48'd0);
        chk("R12 rows", bank_row, 48'd0);
        chk("R12 cmd", {44'd0, cmd_code}, 48'd0);
        err_is("R12 err", 1'b0, 3'd0);
        @(negedge clk); rst_n = 1'b1;

        // table: R1 decode, R2 open, R4 precharge
        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i].cmd, VEC[i].ba, VEC[i].addr, 1'b0);
            chk("R1 cmd_code", {44'd0, cmd_code}, {44'd0, VEC[i].cmd});
            chk("R2/R4 bank_open", {44'd0, bank_open}, {44'd0, VEC[i].open});
            err_is("R1 no error", VEC[i].err, VEC[i].cause);
        end

        // R2 row readout
        issue(C_ACT, 2'd3, 12'h5A5, 1'b0);
        chk("R2 row", {36'd0, bank_row[47:36]}, 48'h5A5);
        chk("R2 idle row zero", {36'd0, bank_row[11:0]}, 48'd0);
        // R3 activate on open bank
        issue(C_ACT, 2'd3, 12'h111, 1'b0);
        err_is("R3 cause", 1'b1, 3'd1);
        chk("R3 row kept", {36'd0, bank_row[47:36]}, 48'h5A5);
        // R11 first cause kept
        issue(C_WR, 2'd0, 12'h000, 1'b0);
        err_is("R11 first cause", 1'b1, 3'd1);
        issue(C_NOP, 2'd0, 12'h000, 1'b1);
        err_is("R11 clear", 1'b0, 3'd0);
        // R11 clear beats coincident violation
        issue(C_RD, 2'd0, 12'h000, 1'b1);
        err_is("R11 clear wins", 1'b0, 3'd0);
        // R5 access to idle bank
        issue(C_RD, 2'd1, 12'h000, 1'b0);
        err_is("R5 cause", 1'b1, 3'd2);
        chk("R5 no state change", {44'd0, bank_open}, 48'b1000);
        issue(C_NOP, 2'd0, 12'h000, 1'b1);
        // R9 mode load and refresh while open
        issue(C_MLD, 2'd0, 12'h001, 1'b0);
        err_is("R9 mode load", 1'b1, 3'd3);
        issue(C_NOP, 2'd0, 12'h000, 1'b1);
        issue(C_AREF, 2'd0, 12'h000, 1'b0);
        err_is("R9 auto refresh", 1'b1, 3'd4);
        issue(C_NOP, 2'd0, 12'h000, 1'b1);
        issue(C_SREF, 2'd0, 12'h000, 1'b0);
        chk("R1 self refresh code", {44'd0, cmd_code}, 48'd8);
        err_is("R9 self refresh", 1'b1, 3'd4);
        issue(C_NOP, 2'd0, 12'h000, 1'b1);
        issue(C_PRE, 2'd0, 12'h400, 1'b0);
        // R9/R6 burst 8 still in force after rejected load
        issue(C_ACT, 2'd0, 12'h010, 1'b0);
        issue(C_RD, 2'd0, 12'h400, 1'b0);
        for (int k = 0; k < 7; k++) begin
            issue(C_NOP, 2'd0, 12'h000, 1'b0);
            chk("R6 BL8 still open", {47'd0, bank_open[0]}, 48'd1);
        end
        issue(C_NOP, 2'd0, 12'h000, 1'b0);
        chk("R6 BL8 closed", {47'd0, bank_open[0]}, 48'd0);
        // R6 BL2
        issue(C_MLD, 2'd0, 12'h001, 1'b0);
        issue(C_NOP, 2'd0, 12'h000, 1'b0);
        issue(C_ACT, 2'd2, 12'h020, 1'b0);
        issue(C_RD, 2'd2, 12'h400, 1'b0);
        chk("R6 BL2 e0", {44'd0, bank_open}, 48'b0100);
        issue(C_NOP, 2'd0, 12'h000, 1'b0);
        chk("R6 BL2 e1", {44'd0, bank_open}, 48'b0100);
        issue(C_NOP, 2'd0, 12'h000, 1'b0);
        chk("R6 BL2 e2", {44'd0, bank_open}, 48'b0000);
        // R6 reserved code acts as BL1
        issue(C_MLD, 2'd0, 12'h005, 1'b0);
        issue(C_NOP, 2'd0, 12'h000, 1'b0);
        issue(C_ACT, 2'd0, 12'h030, 1'b0);
        issue(C_WR, 2'd0, 12'h400, 1'b0);
        chk("R6 BL1 e0", {44'd0, bank_open}, 48'b0001);
        issue(C_NOP, 2'd0, 12'h000, 1'b0);
        chk("R6 BL1 e1", {44'd0, bank_open}, 48'b0000);
        err_is("R6 no error", 1'b0, 3'd0);
        // R7 full page ignores auto precharge
        issue(C_MLD, 2'd0, 12'h007, 1'b0);
        issue(C_NOP, 2'd0, 12'h000, 1'b0);
        issue(C_ACT, 2'd1, 12'h040, 1'b0);
        issue(C_RD, 2'd1, 12'h400, 1'b0);
        for (int k = 0; k < 3; k++) begin
            issue(C_NOP, 2'd0, 12'h000, 1'b0);
            chk("R7 full page open", {44'd0, bank_open}, 48'b0010);
        end
        issue(C_PRE, 2'd0, 12'h400, 1'b0);
        // R8 pending close
        issue(C_MLD, 2'd0, 12'h002, 1'b0);
        issue(C_NOP, 2'd0, 12'h000, 1'b0);
        issue(C_ACT, 2'd3, 12'h050, 1'b0);
        issue(C_RD, 2'd3, 12'h400, 1'b0);
        issue(C_RD, 2'd3, 12'h000, 1'b0);
        err_is("R8 access pending", 1'b1, 3'd6);
        chk("R8 still open", {44'd0, bank_open}, 48'b1000);
        issue(C_NOP, 2'd0, 12'h000, 1'b1);
        issue(C_PRE, 2'd3, 12'h000, 1'b0);
        chk("R8 precharge closes", {44'd0, bank_open}, 48'b0000);
        issue(C_NOP, 2'd0, 12'h000, 1'b0);
        err_is("R8 quiet after", 1'b0, 3'd0);
        // R10 mode-load window
        issue(C_MLD, 2'd0, 12'h000, 1'b0);
        issue(C_ACT, 2'd0, 12'h060, 1'b0);
        err_is("R10 window", 1'b1, 3'd5);
        chk("R10 executed", {44'd0, bank_open}, 48'b0001);
        issue(C_NOP, 2'd0, 12'h000, 1'b1);
        issue(C_PRE, 2'd0, 12'h400, 1'b0);
        issue(C_MLD, 2'd0, 12'h000, 1'b0);
        issue(C_INH, 2'd0, 12'h000, 1'b0);
        err_is("R10 inhibit ok", 1'b0, 3'd0);
        issue(C_ACT, 2'd1, 12'h070, 1'b0);
        err_is("R10 after window", 1'b0, 3'd0);
        chk("R10 opened", {44'd0, bank_open}, 48'b0010);
        // R1 inhibit ignores other pins
        @(negedge clk);
        cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000; cke = 1'b1; addr = 12'h003;
        @(posedge clk); #2;
        chk("R1 inhibit code", {44'd0, cmd_code}, 48'd0);
        err_is("R1 inhibit no effect", 1'b0, 3'd0);
        chk("R1 inhibit state", {44'd0, bank_open}, 48'b0010);
        // R12 reset mid-run
        issue(C_ACT, 2'd1, 12'h070, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2;
        chk("R12 reset open", {44'd0, bank_open}, 48'd0);
        err_is("R12 reset err", 1'b0, 3'd0);
        finish_run();
    end

endmodule